// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block is the host's byte-stream window into the controller's local packet memory. Software first sets a remote pointer and a remaining byte count through the register file. It then issues a sequence of reads or writes on a single data port. Every strobe moves one unit of data: a byte, a little-endian halfword when word mode is selected, or a little-endian 32-bit word when the host makes a wide access. After each strobe the pointer moves past the data just moved and the remaining count falls by the same amount.

The local memory has two windows. The first is a 32-byte identity area, refilled on reset with each byte of the station address written twice and a signature byte at the end. The second is the packet RAM. Any byte that falls outside both windows reads as all ones and ignores writes. The pointer follows the receive ring: when it lands exactly on the ring end, it is reloaded with the ring start. When the count runs out, a one-cycle completion pulse goes to the interrupt status logic.

Top module: `rdma_port`

## Requirements
- R1: After reset, `cur_addr` and `remain_cnt` are 0 and `dma_done` is low. Identity bytes 2k and 2k+1 both hold station-address byte k for k=0..5, where byte 0 is `MAC[47:40]`. Bytes 12..27 hold 0x00 and bytes 28..31 hold 0x57.
- R2: With `word_mode`=0 and `acc_wide`=0, a strobe moves one byte in `acc_rdata[7:0]` or `acc_wdata[7:0]`. The pointer advances by 1 and the count falls by 1.
- R3: With `word_mode`=1 and `acc_wide`=0, a strobe moves two bytes at the pointer with bit 0 cleared, the lower address in bits [7:0]. The pointer advances by 2 from its unaligned value.
- R4: With `acc_wide`=1, a strobe moves four bytes, little-endian, starting at the pointer with bit 0 cleared. The pointer advances by 4.
- R5: If the advanced pointer equals `ring_stop`, it is replaced by `ring_start`.
- R6: If the count before a strobe is at most the access size, the count becomes 0 and `dma_done` is high for exactly the next cycle. Otherwise the count falls by the access size and `dma_done` stays low.
- R7: A write strobe while the count is 0 has no effect: memory, pointer and count are all unchanged, and no pulse is raised.
- R8: A read strobe while the count is 0 still returns data and advances the pointer, and it raises `dma_done`.
- R9: A byte whose address is at least 32 and outside [`PRAM_BASE`, `PRAM_BASE`+`PRAM_BYTES`) reads as 0xFF and ignores writes. Byte lanes beyond the access size read as 0x00.
- R10: `ld_addr_en` and `ld_cnt_en` load the pointer and the count, visible from the next cycle. A strobe in the same cycle as a load moves data but does not update the pointer or the count.
- R11: The identity area is writable through the port. A written byte reads back until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: non-wide strobes move 2 bytes |
| ring_start | input | AW | Ring first byte address |
| ring_stop | input | AW | Ring end byte address (exclusive) |
| ld_addr_en | input | 1 | Load pointer |
| ld_addr_val | input | AW | Pointer load value |
| ld_cnt_en | input | 1 | Load remaining count |
| ld_cnt_val | input | CW | Count load value |
| acc_req | input | 1 | Access strobe, one access per cycle high |
| acc_wr | input | 1 | 1: write, 0: read |
| acc_wide | input | 1 | 32-bit host access |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, valid in the strobe cycle |
| cur_addr | output | AW | Current remote pointer |
| remain_cnt | output | CW | Remaining byte count |
| dma_done | output | 1 | One-cycle completion pulse |

## Verification
The port is driven with byte, halfword and wide accesses, each written and then read back bytewise. This separates lane ordering faults from pointer step faults. Odd starting pointers in halfword mode and a wide access with address bit 1 set show whether bit 0 is cleared for memory while the pointer keeps its raw value. Count values just above, equal to and below the access size isolate the exhaustion compare, and writes and reads at count zero show the asymmetric blocking. Pointers placed before the ring end, past the packet RAM and in the gap between windows cover the wrap and the all-ones reads.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ID_BYTES  = 32;
  localparam int LANES     = 4;
  localparam logic [7:0] ID_SIG = 8'h57;

  // bytes per strobe
  function automatic logic [2:0] step_size(input logic wide, input logic word);
    if (wide)      return 3'd4;
    else if (word) return 3'd2;
    else           return 3'd1;
  endfunction

  // reset value of identity byte j: each source byte doubled
  function automatic logic [7:0] id_seed(input logic [47:0] mac, input int j);
    int k;
    k = j / 2;
    if (k < 6)        return mac[47 - 8*k -: 8];
    else if (k >= 14) return ID_SIG;
    else              return 8'h00;
  endfunction
endpackage

// File: rtl/rdma_bank.sv
module rdma_bank #(
  parameter int DEPTH = 256,
  localparam int RW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rdma_step.sv
module rdma_step #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cnt,
  input  logic [2:0]    size,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  output logic [AW-1:0] nxt_addr,
  output logic [CW-1:0] nxt_cnt,
  output logic          exhausted
);
  logic [AW-1:0] sum;

  always_comb begin
    sum       = addr + AW'(size);
    nxt_addr  = (sum == ring_stop) ? ring_start : sum;
    exhausted = (cnt <= CW'(size));
    nxt_cnt   = exhausted ? '0 : cnt - CW'(size);
  end
endmodule

// File: rtl/rdma_store.sv
module rdma_store
  import rdma_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int unsigned PRAM_BASE  = 16'h4000,
  parameter int unsigned PRAM_BYTES = 1024,
  parameter logic [47:0] MAC        = 48'h02005E102030,
  localparam int ROWS = PRAM_BYTES / LANES,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [AW-1:0] base_addr,
  input  logic [2:0]    size,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam logic [AW:0] PB = (AW+1)'(PRAM_BASE);
  localparam logic [AW:0] PL = (AW+1)'(PRAM_BYTES);

  logic [AW:0]  b_addr  [LANES];
  logic [AW:0]  b_off   [LANES];
  logic [LANES-1:0] active, in_id, in_pram;
  logic [7:0]   lane_q  [LANES];
  logic [7:0]   rd_byte [LANES];
  logic [7:0]   id_mem  [ID_BYTES];

  // per-byte address decode
  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign b_addr[i]  = {1'b0, base_addr} + (AW+1)'(i);
    assign b_off[i]   = b_addr[i] - PB;
    assign active[i]  = (size > 3'(i));
    assign in_id[i]   = (b_addr[i] < (AW+1)'(ID_BYTES));
    assign in_pram[i] = (b_addr[i] >= PB) && (b_off[i] < PL);

    always_comb begin
      if (!active[i])      rd_byte[i] = 8'h00;
      else if (in_id[i])   rd_byte[i] = id_mem[b_addr[i][4:0]];
      else if (in_pram[i]) rd_byte[i] = lane_q[b_off[i][1:0]];
      else                 rd_byte[i] = 8'hFF;
    end
  end

  // packet RAM as four byte-wide banks, one per low address pair
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0]    sel;
    logic [RW-1:0] row;
    logic          we;
    logic [7:0]    wd;

    always_comb begin
      sel = 2'(l) - b_off[0][1:0];
      row = b_off[sel][RW+1:2];
      we  = acc_en && acc_wr && active[sel] && in_pram[sel];
      wd  = wdata[8*sel +: 8];
    end

    rdma_bank #(.DEPTH(ROWS)) u_bank (
      .clk   (clk),
      .we    (we),
      .addr  (row),
      .wdata (wd),
      .rdata (lane_q[l])
    );
  end

  // identity area: reset-seeded, writable
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ID_BYTES; j++) id_mem[j] <= id_seed(MAC, j);
    end else if (acc_en && acc_wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (active[i] && in_id[i]) id_mem[b_addr[i][4:0]] <= wdata[8*i +: 8];
      end
    end
  end

  assign rdata = {rd_byte[3], rd_byte[2], rd_byte[1], rd_byte[0]};
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          CW         = 16,
  parameter int unsigned PRAM_BASE  = 16'h4000,
  parameter int unsigned PRAM_BYTES = 1024,
  parameter logic [47:0] MAC        = 48'h02005E102030
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_mode,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  input  logic          ld_addr_en,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt_en,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic          acc_req,
  input  logic          acc_wr,
  input  logic          acc_wide,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remain_cnt,
  output logic          dma_done
);
  logic [2:0]    size;
  logic [AW-1:0] mem_addr;
  logic          blocked, go, loading;
  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] nxt_cnt;
  logic          exhausted;

  always_comb begin
    size     = step_size(acc_wide, word_mode);
    mem_addr = (size != 3'd1) ? {cur_addr[AW-1:1], 1'b0} : cur_addr;
    blocked  = acc_wr && (remain_cnt == '0);
    go       = acc_req && !blocked;
    loading  = ld_addr_en || ld_cnt_en;
  end

  rdma_step #(.AW(AW), .CW(CW)) u_step (
    .addr       (cur_addr),
    .cnt        (remain_cnt),
    .size       (size),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .nxt_addr   (nxt_addr),
    .nxt_cnt    (nxt_cnt),
    .exhausted  (exhausted)
  );

  rdma_store #(
    .AW(AW), .PRAM_BASE(PRAM_BASE), .PRAM_BYTES(PRAM_BYTES), .MAC(MAC)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (go),
    .acc_wr    (acc_wr),
    .base_addr (mem_addr),
    .size      (size),
    .wdata     (acc_wdata),
    .rdata     (acc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      remain_cnt <= '0;
      dma_done   <= 1'b0;
    end else begin
      dma_done <= 1'b0;
      if (ld_addr_en) cur_addr   <= ld_addr_val;
      if (ld_cnt_en)  remain_cnt <= ld_cnt_val;
      if (go && !loading) begin
        cur_addr   <= nxt_addr;
        remain_cnt <= nxt_cnt;
        dma_done   <= exhausted;
      end
    end
  end
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int          AW        = 16,
  parameter int          CW        = 16,
  parameter int unsigned PRAM_BASE = 16'h4000
) (
  input logic          clk,
  input logic          rst,
  input logic          word_mode,
  input logic [AW-1:0] ring_start,
  input logic [AW-1:0] ring_stop,
  input logic          ld_addr_en,
  input logic          ld_cnt_en,
  input logic          acc_req,
  input logic          acc_wr,
  input logic          acc_wide,
  input logic [31:0]   acc_rdata,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] remain_cnt,
  input logic          dma_done
);
  logic [2:0] sz;
  logic       no_ld, live;
  assign sz    = acc_wide ? 3'd4 : (word_mode ? 3'd2 : 3'd1);
  assign no_ld = !ld_addr_en && !ld_cnt_en;
  assign live  = acc_req && no_ld && !(acc_wr && remain_cnt == '0);

  AST_WR_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_wr && remain_cnt == '0 && no_ld |=> $stable(cur_addr) && !dma_done); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dma_done |-> $past(acc_req) && ($past(remain_cnt) <= CW'($past(sz)))); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    live && remain_cnt > CW'(sz) |=> remain_cnt == $past(remain_cnt) - CW'($past(sz)) && !dma_done); // R6

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
    live && AW'(cur_addr + AW'(sz)) == ring_stop |=> cur_addr == $past(ring_start)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_req && no_ld |=> $stable(cur_addr) && $stable(remain_cnt) && !dma_done); // R10

  AST_GAP_READ: assert property (@(posedge clk) disable iff (rst)
    acc_req && !acc_wr && !acc_wide && !word_mode && cur_addr >= AW'(32) &&
    cur_addr < AW'(PRAM_BASE) |-> acc_rdata == 32'h0000_00FF); // R9
endmodule

bind rdma_port rdma_port_chk #(.AW(AW), .CW(CW), .PRAM_BASE(PRAM_BASE)) u_chk (.*);

// File: tb/rdma_port_test.sv
module rdma_port_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [47:0] MAC = 48'h02005E102030;

  logic          clk = 0, rst = 1;
  logic          word_mode = 0;
  logic [AW-1:0] ring_start = 16'h4000, ring_stop = 16'h4400;
  logic          ld_addr_en = 0, ld_cnt_en = 0;
  logic [AW-1:0] ld_addr_val = '0;
  logic [CW-1:0] ld_cnt_val = '0;
  logic          acc_req = 0, acc_wr = 0, acc_wide = 0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   acc_rdata;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain_cnt;
  logic          dma_done;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdma_port #(.AW(AW), .CW(CW), .MAC(MAC)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c);
    @(negedge clk);
    ld_addr_en = 1; ld_addr_val = a; ld_cnt_en = 1; ld_cnt_val = c;
    @(negedge clk);
    ld_addr_en = 0; ld_cnt_en = 0;
  endtask

  task automatic acc(input bit wr, input bit wide, input logic [31:0] wd,
                     output logic [31:0] rd);
    @(negedge clk);
    acc_req = 1; acc_wr = wr; acc_wide = wide; acc_wdata = wd;
    #1 rd = acc_rdata;
    @(negedge clk);
    acc_req = 0; acc_wr = 0; acc_wide = 0;
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    logic [7:0] e;
    chk("R1 addr", 32'(cur_addr), 0);
    chk("R1 cnt", 32'(remain_cnt), 0);
    chk("R1 done", 32'(dma_done), 0);
    word_mode = 0;
    load(0, 32);
    for (int j = 0; j < 32; j++) begin
      if (j < 12)      e = MAC[47 - 8*(j/2) -: 8];
      else if (j < 28) e = 8'h00;
      else             e = 8'h57;
      acc(0, 0, 0, rd);
      chk("R1 id byte", rd, 32'(e));
    end
    chk("R1 id done", 32'(dma_done), 1);
  endtask

  task automatic t_byte;
    logic [31:0] rd;
    word_mode = 0;
    load(16'h4000, 8);
    chk("R10 load addr", 32'(cur_addr), 32'h4000);
    chk("R10 load cnt", 32'(remain_cnt), 8);
    for (int j = 0; j < 4; j++) acc(1, 0, 32'hAB00 | 32'(j + 8'h10), rd);
    chk("R2 addr step", 32'(cur_addr), 32'h4004);
    chk("R2 cnt step", 32'(remain_cnt), 4);
    chk("R2 no done", 32'(dma_done), 0);
    load(16'h4000, 4);
    for (int j = 0; j < 4; j++) begin
      acc(0, 0, 0, rd);
      chk("R2 readback", rd, 32'(j + 8'h10));
    end
  endtask

  task automatic t_word;
    logic [31:0] rd;
    word_mode = 1;
    load(16'h4011, 16);
    acc(1, 0, 32'h0000BEEF, rd);
    chk("R3 odd ptr advance", 32'(cur_addr), 32'h4013);
    chk("R3 cnt", 32'(remain_cnt), 14);
    word_mode = 0;
    load(16'h4010, 2);
    acc(0, 0, 0, rd); chk("R3 low byte", rd, 32'hEF);
    acc(0, 0, 0, rd); chk("R3 high byte", rd, 32'hBE);
    word_mode = 1;
    load(16'h4011, 2);
    acc(0, 0, 0, rd); chk("R3 halfword read", rd, 32'h0000BEEF);
    word_mode = 0;
  endtask

  task automatic t_wide;
    logic [31:0] rd;
    load(16'h4020, 64);
    acc(1, 1, 32'h11223344, rd);
    chk("R4 addr", 32'(cur_addr), 32'h4024);
    chk("R4 cnt", 32'(remain_cnt), 60);
    load(16'h4022, 64);
    acc(1, 1, 32'hA1B2C3D4, rd);
    load(16'h4020, 6);
    acc(0, 0, 0, rd); chk("R4 b0", rd, 32'h44);
    acc(0, 0, 0, rd); chk("R4 b1", rd, 32'h33);
    acc(0, 0, 0, rd); chk("R4 b2 overwritten", rd, 32'hD4);
    acc(0, 0, 0, rd); chk("R4 b3 overwritten", rd, 32'hC3);
    acc(0, 0, 0, rd); chk("R4 b4", rd, 32'hB2);
    acc(0, 0, 0, rd); chk("R4 b5", rd, 32'hA1);
    load(16'h4023, 8);
    acc(0, 1, 0, rd); chk("R4 wide read bit0 cleared", rd, 32'hA1B2C3D4);
  endtask

  task automatic t_wrap;
    logic [31:0] rd;
    ring_start = 16'h4100; ring_stop = 16'h4104;
    word_mode = 1;
    load(16'h4102, 10);
    acc(1, 0, 32'h5A5A, rd);
    chk("R5 word wrap", 32'(cur_addr), 32'h4100);
    word_mode = 0;
    load(16'h4103, 10);
    acc(0, 0, 0, rd);
    chk("R5 byte wrap", 32'(cur_addr), 32'h4100);
    load(16'h4101, 10);
    acc(0, 0, 0, rd);
    chk("R5 no wrap early", 32'(cur_addr), 32'h4102);
    ring_start = 16'h4000; ring_stop = 16'h4400;
  endtask

  task automatic t_count;
    logic [31:0] rd;
    word_mode = 1;
    load(16'h4040, 3);
    acc(0, 0, 0, rd);
    chk("R6 cnt above size", 32'(remain_cnt), 1);
    chk("R6 no pulse", 32'(dma_done), 0);
    acc(0, 0, 0, rd);
    chk("R6 cnt below size", 32'(remain_cnt), 0);
    chk("R6 pulse", 32'(dma_done), 1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(dma_done), 0);
    word_mode = 0;
    load(16'h4040, 4);
    acc(0, 1, 0, rd);
    chk("R6 equal size cnt", 32'(remain_cnt), 0);
    chk("R6 equal size pulse", 32'(dma_done), 1);
  endtask

  task automatic t_zero;
    logic [31:0] rd;
    load(16'h4030, 1);
    acc(1, 0, 32'h55, rd);
    chk("R6 last byte cnt", 32'(remain_cnt), 0);
    load(16'h4030, 0);
    acc(1, 0, 32'hAA, rd);
    chk("R7 addr held", 32'(cur_addr), 32'h4030);
    chk("R7 cnt held", 32'(remain_cnt), 0);
    chk("R7 no pulse", 32'(dma_done), 0);
    acc(0, 0, 0, rd);
    chk("R7 memory unchanged", rd, 32'h55);
    chk("R8 read advances", 32'(cur_addr), 32'h4031);
    chk("R8 read pulse", 32'(dma_done), 1);
    chk("R8 cnt stays 0", 32'(remain_cnt), 0);
  endtask

  task automatic t_invalid;
    logic [31:0] rd;
    load(16'h0100, 16);
    acc(0, 0, 0, rd); chk("R9 gap byte", rd, 32'h000000FF);
    word_mode = 1;
    acc(0, 0, 0, rd); chk("R9 gap half", rd, 32'h0000FFFF);
    word_mode = 0;
    acc(0, 1, 0, rd); chk("R9 gap wide", rd, 32'hFFFFFFFF);
    load(16'h4400, 4);
    acc(1, 0, 32'h99, rd);
    load(16'h4400, 4);
    acc(0, 0, 0, rd); chk("R9 past ram write dropped", rd, 32'hFF);
    load(16'h43FE, 4);
    acc(1, 1, 32'h12345678, rd);
    load(16'h43FE, 4);
    acc(0, 1, 0, rd); chk("R9 straddle", rd, 32'hFFFF5678);
  endtask

  task automatic t_id_write;
    logic [31:0] rd;
    load(16'h0002, 2);
    acc(1, 0, 32'hC3, rd);
    load(16'h0002, 2);
    acc(0, 0, 0, rd); chk("R11 id write", rd, 32'hC3);
    acc(0, 0, 0, rd); chk("R11 neighbour kept", rd, 32'(MAC[39:32]));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_byte;
    t_word;
    t_wide;
    t_wrap;
    t_count;
    t_zero;
    t_invalid;
    t_id_write;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule